// File: doc/BRIEF.md
# Chained-Acknowledge Vectored Interrupt Logic

This block gathers the interrupt logic of several I/O modules that share one request line to a processor. Each module latches a service request from its device. The shared request output is the OR of all pending requests, so the line by itself does not say which module needs service. When the processor answers with an acknowledge, the acknowledge enters the first module of a fixed chain. A module with nothing pending passes it to the next module in the same cycle. The first pending module stops it there and puts its own vector on the data bus.

The processor uses that vector to branch straight to the matching device service routine, with no poll of every module first. Position in the chain sets the priority: a module nearer the head always wins over one further along. The winning module's pending request clears on the clock edge that ends the acknowledge cycle. The request line falls once no module is pending. An acknowledge that no module claims comes out of the tail of the chain.

Top module: `vec_irq_chain`

## Requirements
- R1: After reset no module is pending, `intReq`, `vecValid` and `ackOut` are low, `grantOneHot` is zero and `vecBus` is zero.
- R2: A high `devReq[i]` at a clock edge makes module i pending. `intReq` is high from the next cycle and stays high while any module is pending.
- R3: While `intAck` is high and at least one module is pending, the pending module with the lowest index claims in the same cycle. `vecValid` goes high and `vecBus` carries VEC_BASE + i*VEC_STEP, where i is the claiming module's index and the sum is truncated to VEC_W bits.
- R4: At most one bit of `grantOneHot` is set, and that bit is the index of the claiming module. `vecBus` is zero whenever `vecValid` is low.
- R5: A claimed module's pending state clears at the clock edge that ends the claim cycle. `intReq` falls in the first cycle in which no module remains pending.
- R6: `ackOut` equals `intAck` when no module is pending, and is low when any module is pending.
- R7: `intAck` with no module pending gives `vecValid` low and `vecBus` zero, and leaves every module's state unchanged.
- R8: If `devReq[i]` is high in the same cycle that module i claims, module i stays pending.
- R9: While `intAck` is low, no module is granted and pending requests are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devReq | input | N_MODS | Per-module device service request, sampled at each edge |
| intAck | input | 1 | Acknowledge from the processor into the head of the chain |
| intReq | output | 1 | Shared request line, the OR of all pending modules |
| ackOut | output | 1 | Acknowledge leaving the tail of the chain, unclaimed |
| vecValid | output | 1 | A module is driving its vector this cycle |
| vecBus | output | VEC_W | Vector of the claiming module, zero otherwise |
| grantOneHot | output | N_MODS | Which module claimed the acknowledge |

## Verification
On every cycle the assertions check four things: the grant is one-hot or zero, an acknowledge with something pending always produces a claim, a claimed module is no longer pending after the edge unless its device asked again, and pending state holds while no acknowledge is present. That chain priority chooses the right module under mixed patterns of requests is shown only by the bench. So are the exact vector values, the timing of the request line falling, and the pass-through of `ackOut` when nothing is pending. The bench compares all of these every cycle against a behavioural model.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int MAX_MODS = 32;

  typedef struct packed {
    logic [MAX_MODS-1:0] claim;
    logic                busEnable;
  } ctrlStrobes_t;
endpackage

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int N_MODS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_MODS-1:0] devReq,
  input  logic              intAck,
  output ctrlStrobes_t      strobes,
  output logic              intReq,
  output logic              ackOut
);
  logic [N_MODS-1:0] pending;
  logic [N_MODS:0]   ackChain;
  logic [N_MODS-1:0] claim;

  if (N_MODS > MAX_MODS || N_MODS < 1) begin : g_badSize
    $error("vec_irq_ctrl: N_MODS out of range");
  end

  assign ackChain[0] = intAck;

  for (genvar i = 0; i < N_MODS; i++) begin : g_link
    assign claim[i]      = ackChain[i] & pending[i];
    assign ackChain[i+1] = ackChain[i] & ~pending[i];

    always_ff @(posedge clk) begin
      if (!rstN) pending[i] <= 1'b0;
      else if (devReq[i]) pending[i] <= 1'b1;
      else if (claim[i]) pending[i] <= 1'b0;
    end
  end

  always_comb begin
    strobes = '0;
    strobes.claim[N_MODS-1:0] = claim;
    strobes.busEnable = |claim;
  end

  assign intReq = |pending;
  assign ackOut = ackChain[N_MODS];

  // R3: an acknowledge that meets a pending module is always claimed
  assert_ack_claimed_R3: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && pending != '0) |-> strobes.busEnable);

  // R5: a claimed module without a fresh request is idle after the edge
  assert_claim_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((claim & ~devReq) != '0) |=> ((pending & $past(claim & ~devReq)) == '0));

  // R9: without an acknowledge nothing pending is lost
  assert_hold_no_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    !intAck |=> ((pending & $past(pending)) == $past(pending)));

  // R2: a device request is pending on the following cycle
  assert_req_raises_R2: assert property (@(posedge clk) disable iff (!rstN)
    (devReq != '0) |=> intReq);
endmodule

// File: rtl/vec_irq_data.sv
module vec_irq_data
  import vec_irq_pkg::*;
#(
  parameter int N_MODS   = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32,
  parameter int VEC_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  output logic              vecValid,
  output logic [VEC_W-1:0]  vecBus,
  output logic [N_MODS-1:0] grantOneHot
);
  logic [VEC_W-1:0] vecTable [N_MODS];
  logic [VEC_W-1:0] driven   [N_MODS];

  for (genvar i = 0; i < N_MODS; i++) begin : g_vec
    localparam int VecVal = VEC_BASE + i * VEC_STEP;
    assign vecTable[i] = VecVal[VEC_W-1:0];
    assign driven[i]   = strobes.claim[i] ? vecTable[i] : '0;
  end

  always_comb begin
    vecBus = '0;
    for (int i = 0; i < N_MODS; i++) vecBus = vecBus | driven[i];
  end

  assign vecValid    = strobes.busEnable;
  assign grantOneHot = strobes.claim[N_MODS-1:0];

  // R4: only one module ever drives the bus
  assert_single_driver_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.claim));

  // R4: an idle bus carries zero
  assert_idle_bus_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    !vecValid |-> (vecBus == '0));
endmodule

// File: rtl/vec_irq_chain.sv
module vec_irq_chain
  import vec_irq_pkg::*;
#(
  parameter int N_MODS   = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32,
  parameter int VEC_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_MODS-1:0] devReq,
  input  logic              intAck,
  output logic              intReq,
  output logic              ackOut,
  output logic              vecValid,
  output logic [VEC_W-1:0]  vecBus,
  output logic [N_MODS-1:0] grantOneHot
);
  ctrlStrobes_t strobes;

  vec_irq_ctrl #(.N_MODS(N_MODS)) i_ctrl (
    .clk(clk), .rstN(rstN), .devReq(devReq), .intAck(intAck),
    .strobes(strobes), .intReq(intReq), .ackOut(ackOut)
  );

  vec_irq_data #(.N_MODS(N_MODS), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
                 .VEC_STEP(VEC_STEP)) i_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .vecValid(vecValid),
    .vecBus(vecBus), .grantOneHot(grantOneHot)
  );

  // R6: an acknowledge leaving the tail means nobody claimed it
  assert_tail_unclaimed_R6: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> (!vecValid && !intReq));
endmodule

// File: tb/test_vec_irq_chain.sv
module test_vec_irq_chain;
  localparam int N = 4;
  localparam int VW = 8;
  localparam int VB = 32;
  localparam int VS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] devReq = '0;
  logic intAck = 1'b0;
  logic intReq, ackOut, vecValid;
  logic [VW-1:0] vecBus;
  logic [N-1:0] grantOneHot;

  int compared = 0;
  int mismatched = 0;
  int modelPend [N];
  bit finished = 0;

  always #4 clk = ~clk;

  vec_irq_chain #(.N_MODS(N), .VEC_W(VW), .VEC_BASE(VB), .VEC_STEP(VS)) i_vec_irq_chain (
    .clk(clk), .rstN(rstN), .devReq(devReq), .intAck(intAck), .intReq(intReq),
    .ackOut(ackOut), .vecValid(vecValid), .vecBus(vecBus), .grantOneHot(grantOneHot)
  );

  task automatic cmp(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int winner();
    if (!intAck) return -1;
    for (int i = 0; i < N; i++) if (modelPend[i] != 0) return i;
    return -1;
  endfunction

  function automatic int anyPend();
    int c = 0;
    foreach (modelPend[i]) c += modelPend[i];
    return (c != 0) ? 1 : 0;
  endfunction

  task automatic checkOutputs();
    int w = winner();
    int expVec = (w >= 0) ? ((VB + w * VS) % (1 << VW)) : 0;
    int expGrant = (w >= 0) ? (1 << w) : 0;
    cmp("R2 intReq", intReq, anyPend());
    cmp("R3 vecValid", vecValid, (w >= 0) ? 1 : 0);
    cmp("R3 vecBus", vecBus, expVec);
    cmp("R4 grantOneHot", grantOneHot, expGrant);
    cmp("R6 ackOut", ackOut, (intAck && anyPend() == 0) ? 1 : 0);
  endtask

  task automatic step(input logic [N-1:0] req, input logic ack);
    int w;
    @(negedge clk);
    devReq = req;
    intAck = ack;
    #2;
    checkOutputs();
    w = winner();
    @(posedge clk);
    if (w >= 0) modelPend[w] = 0;
    for (int i = 0; i < N; i++) if (req[i]) modelPend[i] = 1;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr = 8'hA5;
    foreach (modelPend[i]) modelPend[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    #2;
    cmp("R1 intReq", intReq, 0);
    cmp("R1 vecValid", vecValid, 0);
    cmp("R1 vecBus", vecBus, 0);
    cmp("R1 grantOneHot", grantOneHot, 0);
    cmp("R1 ackOut", ackOut, 0);
    // R7: acknowledge with nothing pending runs off the tail
    step(4'b0000, 1'b1);
    step(4'b0000, 1'b0);
    // R2 then R9: request held without acknowledge
    step(4'b0100, 1'b0);
    step(4'b0000, 1'b0);
    step(4'b0000, 1'b0);
    // R3, R5: claim module 2, then request line falls
    step(4'b0000, 1'b1);
    step(4'b0000, 1'b0);
    // R3 priority: modules 3,1,0 pending, served head first
    step(4'b1011, 1'b0);
    step(4'b0000, 1'b1);
    step(4'b0000, 1'b1);
    step(4'b0000, 1'b1);
    step(4'b0000, 1'b1);
    // R8: re-request during own claim stays pending
    step(4'b0001, 1'b0);
    step(4'b0001, 1'b1);
    step(4'b0000, 1'b1);
    step(4'b0000, 1'b0);
    // mixed patterns
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step((lfsr[2:0] == 3'b000) ? lfsr[7:4] : 4'b0000, lfsr[3]);
    end
    step(4'b0000, 1'b1);
    step(4'b0000, 1'b1);
    step(4'b0000, 1'b1);
    step(4'b0000, 1'b1);
    step(4'b0000, 1'b0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule